// File: doc/BRIEF.md
# Debug Event Down-Counter

This block is a single down-counter for on-chip debug event logic. Two trigger inputs drive it: an advance/start trigger and a stop/reload trigger. A two-bit mode select picks how it reads them. In span mode it measures elapsed cycles between a start and a stop. In tally mode it counts the cycles in which a trigger is active. In watermark mode it times a window and keeps the shortest or the longest window seen so far.

Software writes a reload value through a one-cycle write port. The same write also loads the running count. The count is an output, and so is a zero flag that the trigger logic can combine with other events, for example to act on the Nth occurrence of an event. The watermark result comes out with a flag that shows whether any window has closed since reset.

Top module: `event_down_counter`

## Requirements
- R1: While `rstN` is low at a clock edge, the count becomes 0, `zeroFlag` becomes 1 and `wmValid` becomes 0. `wmResult` becomes all ones if `trackMax` is 0 and zero if `trackMax` is 1.
- R2: A cycle with `regWrEn` high stores `regWrData` as the reload value and as the count, both visible after that edge. Both triggers are ignored in that cycle.
- R3: `zeroFlag` is 1 exactly when the count is 0. A decrement at a count of 0 leaves it at 0 with no wrap.
- R4: In span mode (`modeSel`=0), a high `startTrig` decrements the count at the same edge. The count then decrements at every edge until a stop.
- R5: In span mode, the count still decrements at the edge of the cycle in which `stopTrig` is high, and then holds. If `startTrig` and `stopTrig` are high together while the counter is idle, it decrements exactly once.
- R6: In tally mode (`modeSel`=1), the count drops by exactly one for each cycle with `startTrig` high. It is unchanged in the other cycles.
- R7: In tally mode, a high `stopTrig` loads the count from the reload value and takes priority over a `startTrig` in the same cycle.
- R8: In watermark mode (`modeSel`=2), a `startTrig` while the window is closed opens it and loads the count with `WM_LOAD` (default 0x0FFFFFFF). Each later cycle with the window open decrements the count by one. While the window is closed the count holds.
- R9: In watermark mode, a `startTrig` while the window is open has no effect.
- R10: A `stopTrig` with the window open closes the window at that edge and sets `wmValid`. The interval is `WM_LOAD` minus the count after that edge. `wmResult` takes the interval if it is smaller than the stored value (`trackMax`=0) or larger (`trackMax`=1). Start and stop together while closed give interval 0. A stop while closed is ignored.
- R11: With `modeSel`=3 the count holds and both triggers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| modeSel | input | 2 | 0 span, 1 tally, 2 watermark, 3 hold |
| trackMax | input | 1 | Watermark keeps maximum (1) or minimum (0) |
| startTrig | input | 1 | Start / advance trigger |
| stopTrig | input | 1 | Stop / reload trigger |
| regWrEn | input | 1 | Reload value write strobe |
| regWrData | input | CNT_W | Reload value to write |
| countVal | output | CNT_W | Current count |
| zeroFlag | output | 1 | Count equals zero |
| wmResult | output | CNT_W | Stored watermark interval |
| wmValid | output | 1 | At least one window has closed |

## Verification
Every control flag (span running, window open) and every datapath register shows at the ports one edge after the cycle that disturbs it. A stuck running flag shows as a count that keeps falling or never moves on the next sample. A wrong window flag shows as a reload of the count, or as a missing one, on the next start. A bad compare or interval subtraction shows in `wmResult` at the first sample after a stop. The stimulus therefore samples the outputs after every single cycle, and each window length is chosen so that a min/max or off-by-one error changes the stored value.

// File: rtl/evc_pkg.sv
package evc_pkg;

  typedef enum logic [1:0] {
    MODE_SPAN  = 2'd0,
    MODE_TALLY = 2'd1,
    MODE_WMARK = 2'd2,
    MODE_HOLD  = 2'd3
  } cntMode_e;

  // strobes from control to datapath, at most one load source per cycle
  typedef struct packed {
    logic wrLoad;
    logic reloadLoad;
    logic wmLoad;
    logic decr;
    logic capture;
  } cntStrobe_t;

endpackage

// File: rtl/evc_ctrl.sv
module evc_ctrl
  import evc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       startTrig,
  input  logic       stopTrig,
  input  logic       regWrEn,
  output cntStrobe_t strobe
);

  logic spanRun, spanNext;
  logic windowOpen, openNext;
  logic spanActive;
  cntMode_e curMode;

  assign curMode = cntMode_e'(modeSel);

  always_comb begin
    strobe     = '0;
    spanNext   = 1'b0;
    openNext   = 1'b0;
    spanActive = spanRun | startTrig;
    if (regWrEn) begin
      // a software write owns the cycle; flags keep their value
      strobe.wrLoad = 1'b1;
      spanNext      = spanRun;
      openNext      = windowOpen;
    end else begin
      unique case (curMode)
        MODE_SPAN: begin
          strobe.decr = spanActive;
          spanNext    = spanActive & ~stopTrig;
        end
        MODE_TALLY: begin
          if (stopTrig)       strobe.reloadLoad = 1'b1;
          else if (startTrig) strobe.decr       = 1'b1;
        end
        MODE_WMARK: begin
          if (!windowOpen) begin
            if (startTrig) begin
              strobe.wmLoad = 1'b1;
              if (stopTrig) strobe.capture = 1'b1;
              else          openNext       = 1'b1;
            end
          end else begin
            strobe.decr = 1'b1;
            if (stopTrig) strobe.capture = 1'b1;
            else          openNext       = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spanRun    <= 1'b0;
      windowOpen <= 1'b0;
    end else begin
      spanRun    <= spanNext;
      windowOpen <= openNext;
    end
  end

endmodule

// File: rtl/evc_datapath.sv
module evc_datapath
  import evc_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter logic [CNT_W-1:0] WM_LOAD = 32'h0FFF_FFFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic             trackMax,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countVal,
  output logic             zeroFlag,
  output logic [CNT_W-1:0] wmResult,
  output logic             wmValid
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt, cntNext, reloadReg, interval;
  logic             better;

  always_comb begin
    if (strobe.wrLoad)          cntNext = wrData;
    else if (strobe.reloadLoad) cntNext = reloadReg;
    else if (strobe.wmLoad)     cntNext = WM_LOAD;
    else if (strobe.decr)       cntNext = (cnt == '0) ? cnt : cnt - ONE;
    else                        cntNext = cnt;
  end

  assign interval = WM_LOAD - cntNext;
  assign better   = !wmValid || (trackMax ? (interval > wmResult)
                                          : (interval < wmResult));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      reloadReg <= '0;
      wmResult  <= trackMax ? '0 : '1;
      wmValid   <= 1'b0;
    end else begin
      cnt <= cntNext;
      if (strobe.wrLoad) reloadReg <= wrData;
      if (strobe.capture) begin
        wmValid <= 1'b1;
        if (better) wmResult <= interval;
      end
    end
  end

  assign countVal = cnt;
  assign zeroFlag = (cnt == '0);

endmodule

// File: rtl/event_down_counter.sv
module event_down_counter
  import evc_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter logic [CNT_W-1:0] WM_LOAD = 32'h0FFF_FFFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             trackMax,
  input  logic             startTrig,
  input  logic             stopTrig,
  input  logic             regWrEn,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] countVal,
  output logic             zeroFlag,
  output logic [CNT_W-1:0] wmResult,
  output logic             wmValid
);

  cntStrobe_t strobe;

  evc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .startTrig (startTrig),
    .stopTrig  (stopTrig),
    .regWrEn   (regWrEn),
    .strobe    (strobe)
  );

  evc_datapath #(.CNT_W(CNT_W), .WM_LOAD(WM_LOAD)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .trackMax (trackMax),
    .wrData   (regWrData),
    .countVal (countVal),
    .zeroFlag (zeroFlag),
    .wmResult (wmResult),
    .wmValid  (wmValid)
  );

endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       modeSel,
  input logic             startTrig,
  input logic             stopTrig,
  input logic             regWrEn,
  input logic [CNT_W-1:0] regWrData,
  input logic [CNT_W-1:0] countVal,
  input logic             zeroFlag,
  input logic             wmValid
);

  p_write_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> countVal == $past(regWrData));

  p_zero_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (zeroFlag && !regWrEn && modeSel != 2'd1 && modeSel != 2'd2) |=> zeroFlag);

  p_span_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd0 && !regWrEn && startTrig && !zeroFlag)
      |=> countVal == $past(countVal) - 1);

  p_tally_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd1 && !regWrEn && !stopTrig && startTrig && !zeroFlag)
      |=> countVal == $past(countVal) - 1);

  p_tally_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd1 && !regWrEn && !stopTrig && !startTrig) |=> $stable(countVal));

  p_valid_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    wmValid |=> wmValid);

  p_hold_mode_r11: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd3 && !regWrEn) |=> $stable(countVal));

endmodule

bind event_down_counter evc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .modeSel   (modeSel),
  .startTrig (startTrig),
  .stopTrig  (stopTrig),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .countVal  (countVal),
  .zeroFlag  (zeroFlag),
  .wmValid   (wmValid)
);

// File: tb/test_event_down_counter.sv
module test_event_down_counter;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  modeSel;
  logic        trackMax, startTrig, stopTrig, regWrEn;
  logic [31:0] regWrData;
  logic [31:0] countVal, wmResult;
  logic        zeroFlag, wmValid;

  int totalCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  localparam logic [31:0] WML = 32'h0FFF_FFFF;

  always #2 clk = ~clk;

  event_down_counter i_event_down_counter (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .trackMax(trackMax),
    .startTrig(startTrig), .stopTrig(stopTrig), .regWrEn(regWrEn),
    .regWrData(regWrData), .countVal(countVal), .zeroFlag(zeroFlag),
    .wmResult(wmResult), .wmValid(wmValid)
  );

  typedef struct packed {
    logic [1:0]  md;
    logic        st;
    logic        sp;
    logic        wr;
    logic [31:0] dat;
    logic [31:0] expCnt;
    logic        expZero;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 1'b0, 1'b0, 1'b1, 32'd5,  32'd5, 1'b0, 8'd2},  // R2 write
    '{2'd1, 1'b1, 1'b0, 1'b0, 32'd0,  32'd4, 1'b0, 8'd6},  // R6
    '{2'd1, 1'b0, 1'b0, 1'b0, 32'd0,  32'd4, 1'b0, 8'd6},  // R6 idle
    '{2'd1, 1'b1, 1'b0, 1'b0, 32'd0,  32'd3, 1'b0, 8'd6},  // R6
    '{2'd1, 1'b1, 1'b1, 1'b0, 32'd0,  32'd5, 1'b0, 8'd7},  // R7 priority
    '{2'd1, 1'b0, 1'b0, 1'b1, 32'd1,  32'd1, 1'b0, 8'd2},  // R2
    '{2'd1, 1'b1, 1'b0, 1'b0, 32'd0,  32'd0, 1'b1, 8'd3},  // R3 reach zero
    '{2'd1, 1'b1, 1'b0, 1'b0, 32'd0,  32'd0, 1'b1, 8'd3},  // R3 no wrap
    '{2'd3, 1'b1, 1'b1, 1'b0, 32'd0,  32'd0, 1'b1, 8'd11}, // R11
    '{2'd3, 1'b0, 1'b0, 1'b1, 32'd3,  32'd3, 1'b0, 8'd2},  // R2
    '{2'd3, 1'b1, 1'b0, 1'b0, 32'd0,  32'd3, 1'b0, 8'd11}, // R11
    '{2'd0, 1'b1, 1'b0, 1'b0, 32'd0,  32'd2, 1'b0, 8'd4},  // R4 same edge
    '{2'd0, 1'b0, 1'b0, 1'b0, 32'd0,  32'd1, 1'b0, 8'd4},  // R4 running
    '{2'd0, 1'b0, 1'b1, 1'b0, 32'd0,  32'd0, 1'b1, 8'd5},  // R5 stop cycle counts
    '{2'd0, 1'b0, 1'b0, 1'b0, 32'd0,  32'd0, 1'b1, 8'd5},  // R5 halted
    '{2'd0, 1'b0, 1'b0, 1'b1, 32'd10, 32'd10, 1'b0, 8'd2}, // R2
    '{2'd0, 1'b1, 1'b1, 1'b0, 32'd0,  32'd9, 1'b0, 8'd5},  // R5 one-cycle
    '{2'd0, 1'b0, 1'b0, 1'b0, 32'd0,  32'd9, 1'b0, 8'd5},  // R5 closed
    '{2'd1, 1'b1, 1'b1, 1'b1, 32'd7,  32'd7, 1'b0, 8'd2},  // R2 triggers ignored
    '{2'd1, 1'b1, 1'b0, 1'b0, 32'd0,  32'd6, 1'b0, 8'd6},  // R6
    '{2'd1, 1'b0, 1'b1, 1'b0, 32'd0,  32'd7, 1'b0, 8'd7}   // R7 new reload value
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] md, input logic st, input logic sp,
                      input logic wr, input logic [31:0] dat);
    modeSel = md; startTrig = st; stopTrig = sp; regWrEn = wr; regWrData = dat;
    @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; trackMax = 1'b0;
    modeSel = 2'd0; startTrig = 1'b0; stopTrig = 1'b0; regWrEn = 1'b0; regWrData = '0;
    repeat (3) @(negedge clk);
    chk("R1 count", countVal, 32'd0);
    chk("R1 zero", {31'd0, zeroFlag}, 32'd1);
    chk("R1 valid", {31'd0, wmValid}, 32'd0);
    chk("R1 min neutral", wmResult, 32'hFFFF_FFFF);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].md, VEC[i].st, VEC[i].sp, VEC[i].wr, VEC[i].dat);
      chk($sformatf("R%0d count vec%0d", VEC[i].req, i), countVal, VEC[i].expCnt);
      chk($sformatf("R3 zero vec%0d", i), {31'd0, zeroFlag}, {31'd0, VEC[i].expZero});
    end

    // watermark, minimum tracking
    step(2'd2, 1'b1, 1'b0, 1'b0, 0);
    chk("R8 load", countVal, WML);
    step(2'd2, 1'b0, 1'b0, 1'b0, 0);
    chk("R8 decr", countVal, WML - 1);
    step(2'd2, 1'b1, 1'b0, 1'b0, 0);
    chk("R9 start ignored", countVal, WML - 2);
    step(2'd2, 1'b0, 1'b1, 1'b0, 0);
    chk("R10 min first", wmResult, 32'd3);
    chk("R10 valid", {31'd0, wmValid}, 32'd1);
    step(2'd2, 1'b0, 1'b0, 1'b0, 0);
    chk("R8 closed hold", countVal, WML - 3);
    step(2'd2, 1'b0, 1'b1, 1'b0, 0);
    chk("R10 stop closed", countVal, WML - 3);
    chk("R10 stop closed res", wmResult, 32'd3);
    step(2'd2, 1'b1, 1'b0, 1'b0, 0);
    step(2'd2, 1'b0, 1'b1, 1'b0, 0);
    chk("R10 min lower", wmResult, 32'd1);
    step(2'd2, 1'b1, 1'b0, 1'b0, 0);
    step(2'd2, 1'b0, 1'b0, 1'b0, 0);
    step(2'd2, 1'b0, 1'b0, 1'b0, 0);
    step(2'd2, 1'b0, 1'b1, 1'b0, 0);
    chk("R10 min keeps", wmResult, 32'd1);
    step(2'd2, 1'b1, 1'b1, 1'b0, 0);
    chk("R10 zero window", wmResult, 32'd0);
    chk("R8 zero window load", countVal, WML);

    // watermark, maximum tracking
    trackMax = 1'b1; rstN = 1'b0;
    step(2'd2, 1'b0, 1'b0, 1'b0, 0);
    chk("R1 max neutral", wmResult, 32'd0);
    chk("R1 valid cleared", {31'd0, wmValid}, 32'd0);
    rstN = 1'b1;
    step(2'd2, 1'b1, 1'b0, 1'b0, 0);
    step(2'd2, 1'b0, 1'b0, 1'b0, 0);
    step(2'd2, 1'b0, 1'b1, 1'b0, 0);
    chk("R10 max first", wmResult, 32'd2);
    step(2'd2, 1'b1, 1'b0, 1'b0, 0);
    step(2'd2, 1'b0, 1'b1, 1'b0, 0);
    chk("R10 max keeps", wmResult, 32'd2);

    done = 1'b1;
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      totalCnt++;
      failCnt++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

endmodule